// File: doc/BRIEF.md
# Streaming Jacobi Sweep Stage

This block applies one iteration of a four-neighbour averaging (Jacobi) update to a matrix that streams through it in raster order, sixteen signed 16-bit lanes per transfer. Each updated element is the quarter-sum of the elements to its left, to its right, one row up and one row down. Any neighbour outside the matrix counts as zero. Within each transfer only the fourteen interior lanes are recomputed. The two edge lanes lack an in-block neighbour on one side, so they leave with their incoming values.

A stream opens with one header transfer that gives the row length and the row count. The stage forwards that header unchanged and emits the updated blocks in the order the input blocks arrived. Identical stages can therefore be chained, one stage per iteration, and all of them run at the same time. Two banks of on-chip row storage supply the row above and the centre row while the row below streams in. Updated blocks for a row leave as the next row arrives. The last row is flushed internally using zeros as the row below. Both sides use valid/ready handshakes.

Top module: `jacobi_stage`

## Requirements
- R1: A header transfer is marked by `i_hdr`=1. Bits [15:0] give the row length in elements and bits [31:16] give the row count. The header is forwarded as the first output of its matrix with `o_hdr`=1 and all 256 data bits unchanged.
- R2: Interior lane l (1 to 14) of an output block is computed as follows. The four signed 16-bit neighbours are sign-extended and summed. The sum is shifted arithmetically right by 2 and truncated to 16 bits. Lane l occupies data bits [16l+15:16l].
- R3: Lanes 0 and 15 of every output data block equal the same lanes of the corresponding input block.
- R4: A neighbour above the first row or below the last row contributes zero.
- R5: Output data blocks leave in input raster order. An unstalled header appears at the output 2 cycles after it is accepted.
- R6: While `o_valid`=1 and `o_ready`=0, `i_ready` is 0 and the output holds its value. No block is lost or duplicated under any pattern of stalls.
- R7: After the last input block of a matrix, the stage completes the last row without further input. It then accepts a new header. For a 1-row, 1-block matrix with no stalls, the updated block appears 3 cycles after its input is accepted.
- R8: The sticky flag `err` is set by a header of any of the following kinds: a zero row length, a row length that is not a multiple of 16, a row length above 16·MAX_BLK, or a zero row count. Only reset clears `err`.
- R9: From the offending header onward, while `err` is set, every input transfer is forwarded unchanged, header flag included.
- R10: Data transfers (`i_hdr`=0) that arrive while a header is expected are consumed and produce no output.
- R11: During and right after reset, `o_valid` and `err` are 0. After reset, `i_ready` is 1 while the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input transfer valid |
| i_ready | output | 1 | Stage accepts an input transfer |
| i_hdr | input | 1 | Input transfer is a header |
| i_data | input | 256 | Input lanes or header fields |
| o_valid | output | 1 | Output transfer valid |
| o_ready | input | 1 | Downstream accepts the output |
| o_hdr | output | 1 | Output transfer is a header |
| o_data | output | 256 | Updated lanes or forwarded header |
| err | output | 1 | Sticky malformed-header flag |

## Verification
Two registers stand between acceptance and the output. A header or a bypassed transfer therefore becomes visible 2 cycles after acceptance. The updated block of row k-1 becomes visible 2 cycles after the matching block of row k is accepted. The final row of a 1-row, 1-block matrix becomes visible 3 cycles after its input, because one extra cycle generates the internal flush beat. The bench drives and samples on the falling edge and keeps an in-order scoreboard, so stalled runs are checked by sequence rather than by cycle. On one unstalled run it records the acceptance and emission cycles and checks the 2-cycle and 3-cycle distances exactly.

// File: rtl/jacobi_pkg.sv
package jacobi_pkg;

  localparam int LEN_W  = 16;
  localparam int ROWS_W = 16;

  typedef enum logic [1:0] {
    M_WAIT,
    M_STREAM,
    M_FLUSH,
    M_BYPASS
  } mode_t;

  function automatic logic hdr_valid(input logic [LEN_W-1:0] len,
                                     input logic [ROWS_W-1:0] rows,
                                     input int lanes, input int max_blk);
    int l;
    l = int'(len);
    return (l != 0) && (rows != '0) && ((l % lanes) == 0) && ((l / lanes) <= max_blk);
  endfunction

endpackage

// File: rtl/jacobi_seq.sv
module jacobi_seq
  import jacobi_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int MAX_BLK = 256,
  localparam int CW     = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1,
  localparam int NBW    = CW + 1,
  localparam int RW     = ROWS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              i_valid,
  input  logic              i_hdr,
  input  logic [LEN_W-1:0]  i_len,
  input  logic [ROWS_W-1:0] i_rows,
  output logic              i_ready,
  output logic              take,
  output logic              calc,
  output logic              zero_in,
  output logic              emit,
  output logic              top_zero,
  output logic              wr,
  output logic [CW-1:0]     col,
  output logic              older,
  output logic              err
);

  mode_t          mode;
  logic [NBW-1:0] nblk;
  logic [RW-1:0]  nrow;
  logic [RW-1:0]  row;
  logic           col_last;
  logic           hdr_fire;

  assign col_last = ({1'b0, col} == (nblk - 1'b1));
  assign hdr_fire = (mode == M_WAIT) && i_valid && adv && i_hdr;
  assign top_zero = (row < RW'(2));

  always_comb begin
    i_ready = 1'b0;
    take    = 1'b0;
    calc    = 1'b0;
    zero_in = 1'b0;
    emit    = 1'b1;
    wr      = 1'b0;
    case (mode)
      M_WAIT: begin
        i_ready = adv;
        take    = hdr_fire;
      end
      M_STREAM: begin
        i_ready = adv;
        take    = i_valid && adv;
        calc    = 1'b1;
        emit    = (row != '0);
        wr      = i_valid && adv;
      end
      M_FLUSH: begin
        take    = adv;
        calc    = 1'b1;
        zero_in = 1'b1;
      end
      default: begin
        i_ready = adv;
        take    = i_valid && adv;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= M_WAIT;
      nblk  <= '0;
      nrow  <= '0;
      row   <= '0;
      col   <= '0;
      older <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (mode)
        M_WAIT: begin
          if (hdr_fire) begin
            if (hdr_valid(i_len, i_rows, LANES, MAX_BLK)) begin
              nblk  <= NBW'(int'(i_len) / LANES);
              nrow  <= RW'(i_rows);
              row   <= '0;
              col   <= '0;
              older <= 1'b0;
              mode  <= M_STREAM;
            end else begin
              err  <= 1'b1;
              mode <= M_BYPASS;
            end
          end
        end
        M_STREAM, M_FLUSH: begin
          if (take) begin
            if (col_last) begin
              col   <= '0;
              older <= ~older;
              row   <= row + 1'b1;
              if (mode == M_FLUSH) begin
                mode <= M_WAIT;
              end else if ((row + 1'b1) == nrow) begin
                mode <= M_FLUSH;
              end
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/jacobi_rowbuf.sv
module jacobi_rowbuf #(
  parameter int DW    = 256,
  parameter int DEPTH = 256,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic              wsel,
  input  logic [DW-1:0]     wdata,
  output logic [1:0][DW-1:0] rdata
);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        q <= mem[addr];
        if (we && (wsel == 1'(b))) begin
          mem[addr] <= wdata;
        end
      end
    end

    assign rdata[b] = q;
  end

endmodule

// File: rtl/jacobi_avg.sv
module jacobi_avg #(
  parameter int LANES = 16,
  parameter int W     = 16,
  localparam int DW   = LANES * W,
  localparam int SW   = W + 2
) (
  input  logic [DW-1:0] top,
  input  logic [DW-1:0] ctr,
  input  logic [DW-1:0] bot,
  input  logic          top_zero,
  output logic [DW-1:0] res
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == 0 || l == LANES - 1) begin : g_edge
      assign res[l*W +: W] = ctr[l*W +: W];
    end else begin : g_mid
      logic signed [W-1:0]  up;
      logic signed [W-1:0]  dn;
      logic signed [W-1:0]  lf;
      logic signed [W-1:0]  rt;
      logic signed [SW-1:0] sum;
      assign up  = top_zero ? '0 : top[l*W +: W];
      assign dn  = bot[l*W +: W];
      assign lf  = ctr[(l-1)*W +: W];
      assign rt  = ctr[(l+1)*W +: W];
      assign sum = SW'(up) + SW'(dn) + SW'(lf) + SW'(rt);
      assign res[l*W +: W] = sum[SW-1:2];
    end
  end

endmodule

// File: rtl/jacobi_stage.sv
module jacobi_stage
  import jacobi_pkg::*;
#(
  parameter int LANES   = 16,
  parameter int W       = 16,
  parameter int MAX_BLK = 256,
  localparam int DW     = LANES * W,
  localparam int CW     = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          i_valid,
  output logic          i_ready,
  input  logic          i_hdr,
  input  logic [DW-1:0] i_data,
  output logic          o_valid,
  input  logic          o_ready,
  output logic          o_hdr,
  output logic [DW-1:0] o_data,
  output logic          err
);

  logic              adv;
  logic              take, calc, zero_in, emit, top_zero, wr, older;
  logic [CW-1:0]     col;
  logic [1:0][DW-1:0] rd;

  logic              s1_v, s1_calc, s1_emit, s1_tz, s1_older, s1_hdr;
  logic [DW-1:0]     s1_data;
  logic [DW-1:0]     top_blk, ctr_blk, avg_blk;

  assign adv = !o_valid || o_ready;

  jacobi_seq #(.LANES(LANES), .MAX_BLK(MAX_BLK)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .i_valid  (i_valid),
    .i_hdr    (i_hdr),
    .i_len    (i_data[LEN_W-1:0]),
    .i_rows   (i_data[LEN_W+ROWS_W-1:LEN_W]),
    .i_ready  (i_ready),
    .take     (take),
    .calc     (calc),
    .zero_in  (zero_in),
    .emit     (emit),
    .top_zero (top_zero),
    .wr       (wr),
    .col      (col),
    .older    (older),
    .err      (err)
  );

  jacobi_rowbuf #(.DW(DW), .DEPTH(MAX_BLK)) u_rows (
    .clk   (clk),
    .en    (adv),
    .addr  (col),
    .we    (wr),
    .wsel  (older),
    .wdata (i_data),
    .rdata (rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_calc  <= 1'b0;
      s1_emit  <= 1'b0;
      s1_tz    <= 1'b0;
      s1_older <= 1'b0;
      s1_hdr   <= 1'b0;
      s1_data  <= '0;
    end else if (adv) begin
      s1_v     <= take;
      s1_calc  <= calc;
      s1_emit  <= emit;
      s1_tz    <= top_zero;
      s1_older <= older;
      s1_hdr   <= i_hdr && !calc;
      s1_data  <= zero_in ? '0 : i_data;
    end
  end

  assign top_blk = s1_older ? rd[1] : rd[0];
  assign ctr_blk = s1_older ? rd[0] : rd[1];

  jacobi_avg #(.LANES(LANES), .W(W)) u_avg (
    .top      (top_blk),
    .ctr      (ctr_blk),
    .bot      (s1_data),
    .top_zero (s1_tz),
    .res      (avg_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_hdr   <= 1'b0;
      o_data  <= '0;
    end else if (adv) begin
      o_valid <= s1_v && s1_emit;
      o_hdr   <= s1_hdr;
      o_data  <= s1_calc ? avg_blk : s1_data;
    end
  end

endmodule

// File: rtl/jacobi_stage_chk.sv
module jacobi_stage_chk #(
  parameter int DW = 256
) (
  input logic          clk,
  input logic          rst,
  input logic          i_ready,
  input logic          o_valid,
  input logic          o_ready,
  input logic          o_hdr,
  input logic [DW-1:0] o_data,
  input logic          err
);

  // R6
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |-> !i_ready);

  // R6
  stall_holds_output_chk: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_hdr)));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!o_valid && !err));

endmodule

bind jacobi_stage jacobi_stage_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .i_ready (i_ready),
  .o_valid (o_valid),
  .o_ready (o_ready),
  .o_hdr   (o_hdr),
  .o_data  (o_data),
  .err     (err)
);

// File: tb/jacobi_stage_tb.sv
module jacobi_stage_tb;

  localparam int LANES = 16;
  localparam int W     = 16;
  localparam int MAXB  = 4;
  localparam int DW    = LANES * W;

  typedef logic [DW:0] beat_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          i_valid, i_ready, i_hdr;
  logic [DW-1:0] i_data;
  logic          o_valid, o_ready, o_hdr;
  logic [DW-1:0] o_data;
  logic          err;

  always #4 clk = ~clk;

  jacobi_stage #(.LANES(LANES), .W(W), .MAX_BLK(MAXB)) u_dut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_ready(i_ready), .i_hdr(i_hdr),
    .i_data(i_data), .o_valid(o_valid), .o_ready(o_ready), .o_hdr(o_hdr),
    .o_data(o_data), .err(err)
  );

  beat_t in_q[$];
  beat_t exp_q[$];
  string tag_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  int    rdy_pct = 100;
  int    vld_pct = 100;
  bit    fired   = 1'b0;
  int    hdr_in, hdr_out, dat_in, dat_out;
  int    mat [8][64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input beat_t act, input beat_t exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", '0, '1);
    finish_sim();
  end

  function automatic beat_t hdr_beat(input int len, input int rows);
    beat_t b;
    b = {1'b1, $urandom, $urandom, $urandom, $urandom,
               $urandom, $urandom, $urandom, $urandom};
    b[15:0]  = len[15:0];
    b[31:16] = rows[15:0];
    return b;
  endfunction

  function automatic int nb_val(input int r, input int e, input int rows);
    if (r < 0 || r >= rows) return 0;
    return mat[r][e];
  endfunction

  // style 0: random, 1: extreme alternating, 2: small ramp
  task automatic add_matrix(input int rows, input int nb, input int style, input string req);
    beat_t h, b, x;
    int    s, v;
    h = hdr_beat(nb * LANES, rows);
    in_q.push_back(h);
    exp_q.push_back(h);
    tag_q.push_back("R1");
    for (int r = 0; r < rows; r++) begin
      for (int e = 0; e < nb * LANES; e++) begin
        if (style == 0)      mat[r][e] = int'($signed(16'($urandom)));
        else if (style == 1) mat[r][e] = ((r + e) % 2 == 1) ? 32767 : -32768;
        else                 mat[r][e] = r * 100 + e;
      end
    end
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < nb; c++) begin
        b = '0;
        x = '0;
        for (int l = 0; l < LANES; l++) begin
          int e;
          e = c * LANES + l;
          b[l*W +: W] = 16'(mat[r][e]);
          if (l == 0 || l == LANES - 1) begin
            v = mat[r][e];
          end else begin
            s = nb_val(r - 1, e, rows) + nb_val(r + 1, e, rows) + mat[r][e-1] + mat[r][e+1];
            v = s >>> 2;
          end
          x[l*W +: W] = 16'(v);
        end
        in_q.push_back(b);
        exp_q.push_back(x);
        tag_q.push_back(req);
      end
    end
  endtask

  task automatic run(input int limit);
    int idle = 0;
    int n = 0;
    while (n < limit && idle < 12) begin
      @(negedge clk);
      o_ready = (($urandom % 100) < rdy_pct);
      if (!i_valid || fired) begin
        if (in_q.size() > 0 && (($urandom % 100) < vld_pct)) begin
          i_valid = 1'b1;
          {i_hdr, i_data} = in_q[0];
        end else begin
          i_valid = 1'b0;
        end
      end
      #1;
      fired = i_valid && i_ready;
      if (fired) begin
        if (i_hdr && hdr_in < 0) hdr_in = cyc;
        if (!i_hdr) dat_in = cyc;
        void'(in_q.pop_front());
      end
      if (o_valid && !o_ready)
        chk(!i_ready, "R6 ready under stall", {1'b0, 255'(i_ready)}, '0);
      if (o_valid && o_ready) begin
        if (o_hdr && hdr_out < 0) hdr_out = cyc;
        if (!o_hdr) dat_out = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 extra output", {o_hdr, o_data}, '0);
        end else begin
          chk({o_hdr, o_data} === exp_q[0], tag_q[0], {o_hdr, o_data}, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_q.size() == 0 && exp_q.size() == 0) idle++;
      else idle = 0;
      n++;
    end
    chk(exp_q.size() == 0, "R6 missing output", beat_t'(exp_q.size()), '0);
    fired = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    i_valid = 1'b0;
    o_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!o_valid && !err, "R11 reset state", {1'b0, 254'(0), o_valid, err}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(i_ready && !o_valid && !err, "R11 after reset", {1'b0, 253'(0), i_ready, o_valid, err}, beat_t'(4));
  endtask

  initial begin
    void'($urandom(32'h1bad_5eed));
    rst = 1'b1; i_valid = 1'b0; i_hdr = 1'b0; i_data = '0; o_ready = 1'b1;
    do_reset();

    // R10: stray data before a header is discarded; then R5/R7 latency on a 1x1 matrix
    in_q.push_back({1'b0, {8{32'hdead_beef}}});
    in_q.push_back({1'b0, {8{32'h1234_5678}}});
    hdr_in = -1; hdr_out = -1; dat_in = -1; dat_out = -1;
    add_matrix(1, 1, 0, "R10 R7 R4 single row");
    run(200);
    chk(hdr_out - hdr_in == 2, "R5 header latency", beat_t'(hdr_out - hdr_in), beat_t'(2));
    chk(dat_out - dat_in == 3, "R7 flush latency", beat_t'(dat_out - dat_in), beat_t'(3));

    // R2 R3 R4: unstalled multi-row matrices, back to back headers (R7)
    add_matrix(3, 2, 0, "R2 R3 3x2");
    add_matrix(2, 1, 2, "R4 2x1 ramp");
    run(400);

    // R6: random stalls on both sides; R8 boundary: MAXB blocks accepted
    rdy_pct = 45; vld_pct = 70;
    add_matrix(5, 3, 0, "R6 R2 5x3 stalled");
    add_matrix(4, MAXB, 1, "R2 R3 extremes max length");
    add_matrix(1, MAXB, 0, "R4 single row max length");
    add_matrix(6, 2, 0, "R5 6x2 stalled");
    run(4000);
    chk(!err, "R8 no error on valid headers", beat_t'(err), '0);

    // R8 R9: length not a multiple of 16 -> sticky error and bypass
    rdy_pct = 60; vld_pct = 80;
    begin
      beat_t h, d;
      h = hdr_beat(24, 2);
      in_q.push_back(h);  exp_q.push_back(h);  tag_q.push_back("R9 bad header forwarded");
      for (int k = 0; k < 3; k++) begin
        d = {1'(k == 1), $urandom, $urandom, $urandom, $urandom,
                        $urandom, $urandom, $urandom, $urandom};
        in_q.push_back(d); exp_q.push_back(d); tag_q.push_back("R9 bypass");
      end
    end
    run(400);
    chk(err, "R8 misaligned length", beat_t'(err), beat_t'(1));

    // R8: oversize row length
    rdy_pct = 100; vld_pct = 100;
    do_reset();
    begin
      beat_t h;
      h = hdr_beat((MAXB + 1) * LANES, 1);
      in_q.push_back(h); exp_q.push_back(h); tag_q.push_back("R9 oversize forwarded");
    end
    run(100);
    chk(err, "R8 oversize length", beat_t'(err), beat_t'(1));

    // R8: zero row count
    do_reset();
    begin
      beat_t h;
      h = hdr_beat(LANES, 0);
      in_q.push_back(h); exp_q.push_back(h); tag_q.push_back("R9 zero rows forwarded");
    end
    run(100);
    chk(err, "R8 zero rows", beat_t'(err), beat_t'(1));

    finish_sim();
  end

endmodule